// File: doc/BRIEF.md
# SDRAM Command Decoder and Legality Checker

This block sits on the memory side of an SDRAM command bus and watches it. On every rising clock edge it samples chip select, the three strobes, the clock-enable pin, the bank bits and the address bus. It reports which command was issued and whether that command was legal given what came before. It keeps a state for each of four banks: idle, open, or busy with a burst that ends in an open row or in an automatic precharge. It also holds the mode word and the extended mode word. Both are loaded only by legal mode-set commands.

A violation is reported with a reason code. The bank rules cover a row that is not open, a row that is already open, and a bank closing itself after a burst. Three minimum spacings, each counted in clock cycles and set by a parameter, are also checked: open-to-access, close-to-open, and mode-set-to-next-command. An illegal command never changes the tracked state, so one bad command does not corrupt later verdicts. The pin pattern that would normally stop a burst instead enters deep power down when the clock enable falls on the same edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high on the previous edge and chip select low, the {ras_n,cas_n,we_n} patterns decode to these command codes: 011 open row = 2, 101 read = 3/4, 100 write = 5/6, 010 close = 7/8, 001 refresh = 9 (self refresh entry = 10 if clock enable is now low), 000 mode set = 11/12, 110 burst stop = 13 (deep power down entry = 14 if clock enable is now low), 111 = NOP 1. Chip select high gives 0. Clock enable low on the previous edge gives 15. All outputs are registered and appear after the sampling edge.
- R2: Address bit 10 high turns a read into 4 and a write into 6 (with auto precharge). It turns a close into 8 (all banks). When it is low, the close applies only to the bank on the bank bits.
- R3: A legal mode set with bank bits 00 loads addr into the mode word (code 11). With bank bits 10 it loads the extended word (code 12). The reset values are 0x030 and 0x000.
- R4: A mode set is flagged with reason 8 and loads nothing in any of these cases: the latency field bits 6:4 is not 2 or 3; bits 8:7 or 12:10 are not zero; the burst-length code bits 2:0 is 4, 5 or 6; the code is 7 with bit 3 (interleave) set. An extended set is flagged with reason 8 in any of these cases: its bank bits are not 10; its coverage field bits 2:0 is above 2; bits 4:3 or 12:7 are not zero.
- R5: Mode set, extended set, refresh, self refresh entry and deep power down entry are flagged with reason 2 unless every bank is idle and past its close time.
- R6: Any command other than deselect or NOP that comes fewer than T_MRD cycles after a legal mode set is flagged with reason 1.
- R7: A read or write to an idle bank is flagged with reason 4. An open-row command to a bank that is not idle is flagged with reason 5. An illegal open-row command leaves the bank closed.
- R8: A read or write fewer than T_RCD cycles after the open-row command of its bank is flagged with reason 6.
- R9: An open-row command fewer than T_RP cycles after that bank closed is flagged with reason 7. A close of an open bank starts that count.
- R10: While a bank runs a burst with auto precharge, an open, read, write or close aimed at that bank is flagged with reason 3. A close-all is flagged with reason 3 while any bank is in that state.
- R11: A burst issued at edge n with length L (1, 2, 4 or 8 from mode bits 2:0, or the page length for code 7) keeps its bank busy for commands at edges n+1 to n+L. The auto precharge then starts the close time. When mode bit 9 is set, writes use L = 1.
- R12: Deep power down is entered (deep_pd goes high) by a legal code 14. It is left at the first edge that samples clock enable high again. While it is set, deep_pd stays high and the code is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock-enable pin as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank bits |
| addr | input | 13 | Address bus (bit 10 qualifies reads, writes and closes) |
| cmd_code | output | 4 | Decoded command of the last sampled edge |
| cmd_illegal | output | 1 | High when that command broke a rule |
| illegal_reason | output | 4 | 0 none, 1 mode-set spacing, 2 not all idle, 3 auto-precharge busy, 4 bank closed, 5 bank open, 6 open-to-access, 7 close-to-open, 8 bad mode value |
| mode_word | output | 13 | Current mode word |
| ext_mode_word | output | 13 | Current extended mode word |
| deep_pd | output | 1 | High while in deep power down |

## Verification
Every strobe pattern is driven once, and the burst-stop pattern is driven both with clock enable held and with it falling, which separates burst stop from deep power down entry. The spacing rules are exercised one cycle too early and then exactly on time, so an off-by-one in any counter shows up as a wrong reason code. A read with auto precharge at burst length four, and a write with the single-write bit set, tell the burst-length counter apart from the write override. Both are observed only through which reason an open-row command gets on each following edge. Out-of-range mode values are issued after a good one, which shows that rejected values leave the stored words untouched.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,  CMD_NOP  = 4'd1,  CMD_ACT  = 4'd2,  CMD_RD   = 4'd3,
    CMD_RDA   = 4'd4,  CMD_WR   = 4'd5,  CMD_WRA  = 4'd6,  CMD_PRE  = 4'd7,
    CMD_PREA  = 4'd8,  CMD_REF  = 4'd9,  CMD_SREF = 4'd10, CMD_MRS  = 4'd11,
    CMD_EMRS  = 4'd12, CMD_BST  = 4'd13, CMD_DPD  = 4'd14, CMD_CKOFF = 4'd15
  } cmd_e;

  typedef enum logic [3:0] {
    RSN_NONE = 4'd0, RSN_MRD = 4'd1, RSN_NOT_IDLE = 4'd2, RSN_AP_BUSY = 4'd3,
    RSN_CLOSED = 4'd4, RSN_OPEN = 4'd5, RSN_TRCD = 4'd6, RSN_TRP = 4'd7,
    RSN_BAD_MODE = 4'd8
  } reason_e;

  typedef enum logic [2:0] {
    BK_IDLE = 3'd0, BK_OPEN = 3'd1, BK_RD = 3'd2, BK_WR = 3'd3,
    BK_RD_AP = 3'd4, BK_WR_AP = 3'd5
  } bank_e;
endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
  import sdmon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_prev,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            a10,
  input  logic [BA_W-1:0] ba,
  output cmd_e            cmd
);
  timeunit 1ns; timeprecision 1ps;

  always_comb begin
    cmd = CMD_NOP;
    if (!cke_prev) begin
      cmd = CMD_CKOFF;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
        3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
        3'b000:  cmd = (ba == '0) ? CMD_MRS : CMD_EMRS;
        3'b110:  cmd = cke ? CMD_BST : CMD_DPD;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank
  import sdmon_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             pre,
  input  logic             rw_go,
  input  logic             rw_write,
  input  logic             rw_ap,
  input  logic [CNT_W-1:0] rw_last,
  input  logic             stop_plain,
  input  logic             stop_all,
  output bank_e            state,
  output logic             rcd_busy,
  output logic             rp_busy
);
  timeunit 1ns; timeprecision 1ps;

  localparam int RCD_W = (T_RCD > 1) ? $clog2(T_RCD) : 1;
  localparam int RP_W  = (T_RP  > 1) ? $clog2(T_RP)  : 1;
  localparam logic [RCD_W-1:0] RCD_INIT = RCD_W'(T_RCD - 1);
  localparam logic [RP_W-1:0]  RP_INIT  = RP_W'(T_RP - 1);

  bank_e            state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RCD_W-1:0] rcd_q, rcd_d;
  logic [RP_W-1:0]  rp_q, rp_d;
  logic             in_burst, is_ap, burst_end;

  assign in_burst  = state_q inside {BK_RD, BK_WR, BK_RD_AP, BK_WR_AP};
  assign is_ap     = state_q inside {BK_RD_AP, BK_WR_AP};
  assign burst_end = (cnt_q == '0) || stop_all || (stop_plain && !is_ap);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rcd_d   = (rcd_q != '0) ? rcd_q - 1'b1 : rcd_q;
    rp_d    = (rp_q  != '0) ? rp_q  - 1'b1 : rp_q;
    if (act) begin
      state_d = BK_OPEN;
      rcd_d   = RCD_INIT;
    end else if (pre) begin
      if (state_q != BK_IDLE) begin
        state_d = BK_IDLE;
        rp_d    = RP_INIT;
      end
    end else if (rw_go) begin
      if (rw_write) state_d = rw_ap ? BK_WR_AP : BK_WR;
      else          state_d = rw_ap ? BK_RD_AP : BK_RD;
      cnt_d = rw_last;
    end else if (in_burst) begin
      if (burst_end) begin
        if (is_ap) begin
          state_d = BK_IDLE;
          rp_d    = RP_INIT;
        end else begin
          state_d = BK_OPEN;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BK_IDLE;
      cnt_q   <= '0;
      rcd_q   <= '0;
      rp_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rcd_q   <= rcd_d;
      rp_q    <= rp_d;
    end
  end

  assign state    = state_q;
  assign rcd_busy = (rcd_q != '0);
  assign rp_busy  = (rp_q != '0);

  // R7 / R9: the legality gate only opens a bank that is fully closed
  assert_act_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (state_q == BK_IDLE && !rp_busy));
  // R8: accesses are only let through to an open bank past its open time
  assert_rw_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rw_go |-> (state_q != BK_IDLE && !rcd_busy));
  // R10: an auto-precharge burst keeps its state until its count runs out
  assert_ap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ap && cnt_q != '0 && !stop_all) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/sdmon_modereg.sv
module sdmon_modereg #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_mode,
  input  logic              ld_ext,
  input  logic [ADDR_W-1:0] addr,
  output logic              mode_ok,
  output logic              ext_ok,
  output logic [ADDR_W-1:0] mode_q,
  output logic [ADDR_W-1:0] ext_q
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [ADDR_W-1:0] MODE_RST = ADDR_W'(12'h030);

  logic lat_ok, len_ok;

  assign lat_ok  = (addr[6:4] == 3'd2) || (addr[6:4] == 3'd3);
  assign len_ok  = (addr[2:0] <= 3'd3) || (addr[2:0] == 3'd7 && !addr[3]);
  assign mode_ok = lat_ok && len_ok && (addr[8:7] == 2'b00) && (addr[ADDR_W-1:10] == '0);
  assign ext_ok  = (addr[2:0] <= 3'd2) && (addr[4:3] == 2'b00) && (addr[ADDR_W-1:7] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      ext_q  <= '0;
    end else begin
      if (ld_mode) mode_q <= addr;
      if (ld_ext)  ext_q  <= addr;
    end
  end

  // R4: the stored mode word always carries a supported latency
  assert_mode_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[6:4] == 3'd2 || mode_q[6:4] == 3'd3) && mode_q[8:7] == 2'b00);
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdmon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int PAGE_LEN  = 1024
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cke,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic [ADDR_W-1:0]            addr,
  output logic [3:0]                   cmd_code,
  output logic                         cmd_illegal,
  output logic [3:0]                   illegal_reason,
  output logic [ADDR_W-1:0]            mode_word,
  output logic [ADDR_W-1:0]            ext_mode_word,
  output logic                         deep_pd
);
  timeunit 1ns; timeprecision 1ps;

  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int CNT_W = $clog2(PAGE_LEN);
  localparam int MRD_W = (T_MRD > 1) ? $clog2(T_MRD) : 1;
  localparam logic [MRD_W-1:0] MRD_INIT = MRD_W'(T_MRD - 1);
  localparam logic [BA_W-1:0]  EXT_BA   = BA_W'(2);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  logic       cke_prev_q, dpd_q, dpd_d;
  logic [MRD_W-1:0] mrd_q, mrd_d;
  cmd_e       cmd, cmd_q;
  reason_e    rsn, rsn_q;
  logic       ok, quiet, is_rw, is_write;
  logic       mode_ok, ext_ok;
  logic [ADDR_W-1:0] mode_q, ext_q;
  logic [CNT_W-1:0]  burst_last;

  bank_e          bk_state [NUM_BANKS];
  logic [NUM_BANKS-1:0] bk_rcd, bk_rp, bk_ap, bk_idle;
  logic           all_idle, any_ap, sel_ap, sel_idle, sel_rcd, sel_rp;

  sdmon_decode #(.BA_W(BA_W)) i_decode (
    .cke_prev(cke_prev_q), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(addr[10]), .ba(ba), .cmd(cmd)
  );

  assign quiet    = cmd inside {CMD_DESEL, CMD_NOP, CMD_CKOFF};
  assign is_rw    = cmd inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA};
  assign is_write = cmd inside {CMD_WR, CMD_WRA};

  assign all_idle = &bk_idle;
  assign any_ap   = |bk_ap;
  assign sel_ap   = bk_ap[ba];
  assign sel_idle = (bk_state[ba] == BK_IDLE);
  assign sel_rcd  = bk_rcd[ba];
  assign sel_rp   = bk_rp[ba];

  // legality, highest priority first
  always_comb begin
    rsn = RSN_NONE;
    if (!quiet && mrd_q != '0) begin
      rsn = RSN_MRD;
    end else begin
      case (cmd)
        CMD_MRS, CMD_EMRS, CMD_REF, CMD_SREF, CMD_DPD: begin
          if (!all_idle) rsn = RSN_NOT_IDLE;
          else if (cmd == CMD_MRS && !mode_ok) rsn = RSN_BAD_MODE;
          else if (cmd == CMD_EMRS && (!ext_ok || ba != EXT_BA)) rsn = RSN_BAD_MODE;
        end
        CMD_ACT: begin
          if (sel_ap)         rsn = RSN_AP_BUSY;
          else if (!sel_idle) rsn = RSN_OPEN;
          else if (sel_rp)    rsn = RSN_TRP;
        end
        CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
          if (sel_ap)        rsn = RSN_AP_BUSY;
          else if (sel_idle) rsn = RSN_CLOSED;
          else if (sel_rcd)  rsn = RSN_TRCD;
        end
        CMD_PRE:  if (sel_ap) rsn = RSN_AP_BUSY;
        CMD_PREA: if (any_ap) rsn = RSN_AP_BUSY;
        default:  rsn = RSN_NONE;
      endcase
    end
  end

  assign ok = (rsn == RSN_NONE);

  always_comb begin
    case (mode_q[2:0])
      3'd0:    burst_last = '0;
      3'd1:    burst_last = CNT_W'(1);
      3'd2:    burst_last = CNT_W'(3);
      3'd3:    burst_last = CNT_W'(7);
      3'd7:    burst_last = CNT_W'(PAGE_LEN - 1);
      default: burst_last = '0;
    endcase
    if (is_write && mode_q[9]) burst_last = '0;
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic hit;
      assign hit = (ba == BA_W'(g));
      sdmon_bank #(.T_RCD(T_RCD), .T_RP(T_RP), .CNT_W(CNT_W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_ok),
        .act       (ok && cmd == CMD_ACT && hit),
        .pre       (ok && ((cmd == CMD_PRE && hit) || cmd == CMD_PREA)),
        .rw_go     (ok && is_rw && hit),
        .rw_write  (is_write),
        .rw_ap     (cmd inside {CMD_RDA, CMD_WRA}),
        .rw_last   (burst_last),
        .stop_plain(ok && cmd == CMD_BST),
        .stop_all  (ok && is_rw && !hit),
        .state     (bk_state[g]),
        .rcd_busy  (bk_rcd[g]),
        .rp_busy   (bk_rp[g])
      );
      assign bk_ap[g]   = bk_state[g] inside {BK_RD_AP, BK_WR_AP};
      assign bk_idle[g] = (bk_state[g] == BK_IDLE) && !bk_rp[g];
    end
  endgenerate

  sdmon_modereg #(.ADDR_W(ADDR_W)) i_modereg (
    .clk    (clk),
    .rst_n  (rst_ok),
    .ld_mode(ok && cmd == CMD_MRS),
    .ld_ext (ok && cmd == CMD_EMRS),
    .addr   (addr),
    .mode_ok(mode_ok),
    .ext_ok (ext_ok),
    .mode_q (mode_q),
    .ext_q  (ext_q)
  );

  always_comb begin
    mrd_d = (mrd_q != '0) ? mrd_q - 1'b1 : mrd_q;
    if (ok && cmd inside {CMD_MRS, CMD_EMRS}) mrd_d = MRD_INIT;
    dpd_d = dpd_q;
    if (ok && cmd == CMD_DPD)    dpd_d = 1'b1;
    else if (!cke_prev_q && cke) dpd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      cke_prev_q <= 1'b1;
      cmd_q      <= CMD_DESEL;
      rsn_q      <= RSN_NONE;
      dpd_q      <= 1'b0;
      mrd_q      <= '0;
    end else begin
      cke_prev_q <= cke;
      cmd_q      <= cmd;
      rsn_q      <= rsn;
      dpd_q      <= dpd_d;
      mrd_q      <= mrd_d;
    end
  end

  assign cmd_code       = cmd_q;
  assign cmd_illegal    = (rsn_q != RSN_NONE);
  assign illegal_reason = rsn_q;
  assign mode_word      = mode_q;
  assign ext_mode_word  = ext_q;
  assign deep_pd        = dpd_q;

  // R6: right after a legal mode set, every active command is refused
  generate
    if (T_MRD > 1) begin : g_mrd_chk
      assert_mrd_gap_R6: assert property (@(posedge clk) disable iff (!rst_ok)
        (ok && cmd inside {CMD_MRS, CMD_EMRS}) |=> (quiet || rsn == RSN_MRD));
    end
  endgenerate
  // R4: a refused mode set leaves the mode word as it was
  assert_bad_mode_keep_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd == CMD_MRS && !ok) |=> $stable(mode_q));
  // R12: deep power down is only held while the clock enable stayed low
  assert_dpd_cke_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    dpd_q |-> !cke_prev_q);
endmodule

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                         P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010,
                         P_REF = 4'b0001, P_MRS = 4'b0000, P_BST = 4'b0110;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  cmd_code, illegal_reason;
  logic        cmd_illegal, deep_pd;
  logic [12:0] mode_word, ext_mode_word;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_code(cmd_code), .cmd_illegal(cmd_illegal),
    .illegal_reason(illegal_reason), .mode_word(mode_word),
    .ext_mode_word(ext_mode_word), .deep_pd(deep_pd)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic step(input logic ck, input logic [3:0] p, input logic [1:0] b,
                      input logic [12:0] a);
    @(negedge clk);
    cke = ck; {cs_n, ras_n, cas_n, we_n} = p; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, P_NOP, 2'd0, 13'd0);
  endtask

  // issue one command with clock enable high and check code and verdict
  task automatic issue(input string tag, input logic [3:0] p, input logic [1:0] b,
                       input logic [12:0] a, input int code, input int rsn);
    step(1'b1, p, b, a);
    chk({tag, " code"}, cmd_code, code);
    chk({tag, " reason"}, illegal_reason, rsn);
    chk({tag, " flag"}, cmd_illegal, (rsn != 0) ? 1 : 0);
  endtask

  task automatic t_reset();
    chk("R3 reset mode word", mode_word, 13'h030);
    chk("R3 reset ext word", ext_mode_word, 0);
    chk("R1 reset code", cmd_code, 0);
    chk("R1 reset flag", cmd_illegal, 0);
    chk("R12 reset deep_pd", deep_pd, 0);
  endtask

  task automatic t_decode();
    issue("R1 nop", P_NOP, 0, 0, 1, 0);
    issue("R1 deselect", P_DES, 0, 0, 0, 0);
    issue("R1 open row", P_ACT, 0, 13'h123, 2, 0);
    idle(2);
    issue("R1 read", P_RD, 0, 0, 3, 0);
    issue("R1 write", P_WR, 0, 0, 5, 0);
    issue("R1 burst stop", P_BST, 0, 0, 13, 0);
    issue("R2 close one", P_PRE, 0, 0, 7, 0);
    issue("R2 close all", P_PRE, 0, 13'h400, 8, 0);
    idle(2);
    issue("R1 refresh", P_REF, 0, 0, 9, 0);
  endtask

  task automatic t_mode();
    issue("R3 mode set", P_MRS, 0, 13'h022, 11, 0);
    chk("R3 mode word loaded", mode_word, 13'h022);
    issue("R6 open too soon after mode set", P_ACT, 0, 0, 2, 1);
    idle(1);
    issue("R3 ext set", P_MRS, 2, 13'h041, 12, 0);
    chk("R3 ext word loaded", ext_mode_word, 13'h041);
    idle(2);
    issue("R4 latency 1", P_MRS, 0, 13'h012, 11, 8);
    issue("R4 bits 8:7", P_MRS, 0, 13'h0A2, 11, 8);
    issue("R4 page interleave", P_MRS, 0, 13'h02F, 11, 8);
    chk("R4 mode word kept", mode_word, 13'h022);
    issue("R4 ext bank bits 01", P_MRS, 1, 13'h000, 12, 8);
    issue("R4 ext coverage 3", P_MRS, 2, 13'h003, 12, 8);
    chk("R4 ext word kept", ext_mode_word, 13'h041);
  endtask

  task automatic t_bank_rules();
    issue("R7 read closed bank", P_RD, 1, 0, 3, 4);
    issue("R7 open bank1", P_ACT, 1, 0, 2, 0);
    issue("R7 open twice", P_ACT, 1, 0, 2, 5);
    issue("R8 read one cycle early", P_RD, 1, 0, 3, 6);
    issue("R8 read on time", P_RD, 1, 0, 3, 0);
    issue("R5 refresh with open bank", P_REF, 0, 0, 9, 2);
    issue("R5 mode set with open bank", P_MRS, 0, 13'h022, 11, 2);
    issue("R9 close bank1", P_PRE, 1, 0, 7, 0);
    issue("R9 reopen too soon", P_ACT, 1, 0, 2, 7);
    idle(1);
    issue("R9 reopen on time", P_ACT, 1, 0, 2, 0);
    issue("R9 close bank1 again", P_PRE, 1, 0, 7, 0);
    idle(3);
  endtask

  task automatic t_autopre();
    issue("R10 open bank2", P_ACT, 2, 0, 2, 0);
    idle(2);
    issue("R2 read with auto precharge", P_RD, 2, 13'h400, 4, 0);
    issue("R10 close all while busy", P_PRE, 0, 13'h400, 8, 3);
    for (int i = 0; i < 3; i++) issue("R11 busy during burst", P_ACT, 2, 0, 2, 3);
    issue("R11 close time after burst", P_ACT, 2, 0, 2, 7);
    issue("R11 close time second cycle", P_ACT, 2, 0, 2, 7);
    issue("R11 reopen after burst", P_ACT, 2, 0, 2, 0);
    issue("R11 close bank2", P_PRE, 2, 0, 7, 0);
    idle(3);
    issue("R11 single write mode set", P_MRS, 0, 13'h222, 11, 0);
    idle(2);
    issue("R11 open bank3", P_ACT, 3, 0, 2, 0);
    idle(2);
    issue("R2 write with auto precharge", P_WR, 3, 13'h400, 6, 0);
    issue("R11 single write busy", P_ACT, 3, 0, 2, 3);
    issue("R11 single write close time", P_ACT, 3, 0, 2, 7);
    issue("R11 single write close time 2", P_ACT, 3, 0, 2, 7);
    issue("R11 single write reopen", P_ACT, 3, 0, 2, 0);
    issue("R11 close bank3", P_PRE, 3, 0, 7, 0);
    idle(3);
  endtask

  task automatic t_dpd();
    issue("R12 open bank0", P_ACT, 0, 0, 2, 0);
    step(1'b0, P_BST, 0, 0);
    chk("R12 refused entry code", cmd_code, 14);
    chk("R5 refused entry reason", illegal_reason, 2);
    chk("R12 refused entry deep_pd", deep_pd, 0);
    step(1'b1, P_NOP, 0, 0);
    chk("R12 clock-off code", cmd_code, 15);
    chk("R12 still awake", deep_pd, 0);
    issue("R12 close bank0", P_PRE, 0, 0, 7, 0);
    idle(3);
    step(1'b0, P_BST, 0, 0);
    chk("R12 entry code", cmd_code, 14);
    chk("R12 entry legal", cmd_illegal, 0);
    chk("R12 entered", deep_pd, 1);
    for (int i = 0; i < 2; i++) begin
      step(1'b0, P_NOP, 0, 0);
      chk("R12 held code", cmd_code, 15);
      chk("R12 held", deep_pd, 1);
    end
    step(1'b1, P_NOP, 0, 0);
    chk("R12 exit code", cmd_code, 15);
    chk("R12 exited", deep_pd, 0);
    issue("R12 nop after exit", P_NOP, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = P_DES; ba = '0; addr = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    t_decode();
    t_mode();
    t_bank_rules();
    t_autopre();
    t_dpd();
    summary();
  end
endmodule